// File: doc/BRIEF.md
# Wait-State Bus Sequencer

This block sits between a processor core and the on-chip memories and peripherals. It takes one request at a time from the core: a byte address, a byte or 16-bit word size, a read/write flag and write data. It decodes the address into one of four regions: static RAM, program flash, boot memory and the I/O area. It then drives that region's select and strobe for as long as the region's programmed timing requires, and returns the read data with a one-cycle ready pulse.

Flash, boot and I/O each have their own timing entry, written through a small configuration port. The entry holds a count of wait cycles, during which the strobe stays up and ready stays low, and a count of hold cycles, during which the strobe is down and no new access may begin. Every entry resets to the slowest timing. Static RAM never waits or holds.

A word access at an odd address is split into two byte accesses issued back to back. Each half uses the timing of its own region, and the two bytes are joined little-endian. An address outside every region completes at once with zero data and an error flag.

Top module: `wsb_ctrl`

## Requirements
- R1: Region decode on the 21-bit byte address: flash 0x00000–0x0FFFF, boot 0x10000–0x105FF, SRAM 0x14000–0x14BFF, I/O 0x1F000–0x1F0FF. While the strobe is high, exactly one bit of `bus_sel` is high: bit 0 SRAM, bit 1 flash, bit 2 boot, bit 3 I/O.
- R2: An SRAM access raises ready in the cycle the request is first seen, and the next request can start in the following cycle.
- R3: For a region whose wait count is W, ready rises W cycles after the cycle in which the access starts. The strobe, address and write flag stay steady throughout.
- R4: For a region whose hold count is H, the H cycles after ready have strobe and ready low, so a waiting request starts H cycles later.
- R5: After reset, all three timing entries hold wait 7 and hold 3.
- R6: The config port writes `cfg_wait` (3 bits) and `cfg_hold` (2 bits) into entry `cfg_idx`, with 0 for flash, 1 for boot and 2 for I/O. Index 3 changes no entry.
- R7: A timing write affects only accesses that start after it. An access already in progress, including the second half of a split word, keeps the timing it captured at its start.
- R8: Data lanes are little-endian. An aligned word read returns the slave's 16 bits. A byte read returns the slave's bits 7:0, with bits 15:8 forced to zero.
- R9: A word at an odd address A becomes a byte access at A and then a byte access at A+1, each with its own region's wait and hold. Ready is raised once, with the data {byte(A+1), byte(A)}.
- R10: An address at or above 0x20000, or in an unmapped gap, completes in its start cycle with no strobe and no select. It reads as zero and raises `req_err` for that one cycle. In a split word, only the unmapped half reads as zero, and the error is reported with ready.
- R11: A byte write puts its data on `bus_wdata[7:0]` with `bus_word` low. A split write puts the low byte at A and then the high byte at A+1, both on bits 7:0. An aligned word write passes all 16 bits with `bus_word` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request present; held until ready |
| req_addr | input | 21 | Byte address |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte |
| req_write | input | 1 | 1 = write |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | 16 | Read data, valid with ready |
| req_err | output | 1 | Unmapped access, valid with ready |
| cfg_we | input | 1 | Timing entry write strobe |
| cfg_idx | input | 2 | Entry: 0 flash, 1 boot, 2 I/O |
| cfg_wait | input | 3 | Wait cycles 0–7 |
| cfg_hold | input | 2 | Hold cycles 0–3 |
| bus_sel | output | 4 | One-hot region select |
| bus_stb | output | 1 | Access strobe |
| bus_we | output | 1 | Write flag to slave |
| bus_word | output | 1 | Word-size flag to slave |
| bus_addr | output | 17 | Byte address to slave |
| bus_wdata | output | 16 | Write data to slave |
| bus_rdata | input | 16 | Read data from the selected slave |

## Verification
The bench builds the block with its default widths: 3-bit wait counts, 2-bit hold counts, a 21-bit core address and a 17-bit decoded window. With widths this small, every one of the 32 wait/hold pairs can be swept for each of the three timed regions, which checks the ready latency and the hold gap arithmetically for every combination. The small address window also puts both edges of the decoded space within reach: a word that splits across the flash/boot boundary, a word whose upper half falls off the end of SRAM, and addresses beyond the window.

// File: rtl/wsb_pkg.sv
package wsb_pkg;
    localparam int CPU_AW  = 21;
    localparam int DEC_AW  = 17;
    localparam int DW      = 16;
    localparam int WT_W    = 3;
    localparam int HD_W    = 2;
    localparam int CNT_W   = (WT_W > HD_W) ? WT_W : HD_W;
    localparam int N_TIMED = 3;
    localparam int N_SEL   = 4;

    localparam logic [DEC_AW-1:0] FLASH_HI = 17'h0FFFF;
    localparam logic [DEC_AW-1:0] BOOT_LO  = 17'h10000;
    localparam logic [DEC_AW-1:0] BOOT_HI  = 17'h105FF;
    localparam logic [DEC_AW-1:0] SRAM_LO  = 17'h14000;
    localparam logic [DEC_AW-1:0] SRAM_HI  = 17'h14BFF;
    localparam logic [DEC_AW-1:0] IO_LO    = 17'h1F000;
    localparam logic [DEC_AW-1:0] IO_HI    = 17'h1F0FF;

    typedef enum logic [2:0] {RG_SRAM, RG_FLASH, RG_BOOT, RG_IO, RG_NONE} region_e;
    typedef enum logic [1:0] {S_IDLE, S_WAIT, S_HOLD} seq_state_e;

    typedef struct packed {
        logic [HD_W-1:0] hold;
        logic [WT_W-1:0] waits;
    } timing_t;

    function automatic region_e addr_region(input logic [CPU_AW-1:0] a);
        logic [DEC_AW-1:0] lo;
        lo = a[DEC_AW-1:0];
        if (|a[CPU_AW-1:DEC_AW])              return RG_NONE;
        if (lo <= FLASH_HI)                   return RG_FLASH;
        if (lo >= BOOT_LO && lo <= BOOT_HI)   return RG_BOOT;
        if (lo >= SRAM_LO && lo <= SRAM_HI)   return RG_SRAM;
        if (lo >= IO_LO && lo <= IO_HI)       return RG_IO;
        return RG_NONE;
    endfunction
endpackage

// File: rtl/wsb_decode.sv
module wsb_decode
    import wsb_pkg::*;
(
    input  logic [CPU_AW-1:0] addr,
    output region_e           region,
    output logic [N_SEL-1:0]  sel_oh
);
    always_comb begin
        region = addr_region(addr);
        sel_oh = '0;
        case (region)
            RG_SRAM:  sel_oh[0] = 1'b1;
            RG_FLASH: sel_oh[1] = 1'b1;
            RG_BOOT:  sel_oh[2] = 1'b1;
            RG_IO:    sel_oh[3] = 1'b1;
            default:  sel_oh = '0;
        endcase
    end
endmodule

// File: rtl/wsb_cfg.sv
module wsb_cfg
    import wsb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [1:0]            idx,
    input  logic [WT_W-1:0]       waits,
    input  logic [HD_W-1:0]       hold,
    output timing_t [N_TIMED-1:0] table_q
);
    for (genvar g = 0; g < N_TIMED; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                table_q[g] <= '1;
            else if (we && idx == 2'(g))
                table_q[g] <= '{hold: hold, waits: waits};
        end
    end
endmodule

// File: rtl/wsb_seq.sv
module wsb_seq
    import wsb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [CPU_AW-1:0]     req_addr,
    input  logic                  req_word,
    input  logic                  req_write,
    input  logic [DW-1:0]         req_wdata,
    output logic                  req_ready,
    output logic [DW-1:0]         req_rdata,
    output logic                  req_err,
    input  timing_t [N_TIMED-1:0] cfg_live,
    output logic [CPU_AW-1:0]     cur_addr,
    input  region_e               region,
    input  logic [N_SEL-1:0]      sel_oh,
    output logic [N_SEL-1:0]      bus_sel,
    output logic                  bus_stb,
    output logic                  bus_we,
    output logic                  bus_word,
    output logic [DEC_AW-1:0]     bus_addr,
    output logic [DW-1:0]         bus_wdata,
    input  logic [DW-1:0]         bus_rdata
);
    seq_state_e            state_q, state_d;
    logic [CNT_W-1:0]      cnt_q, cnt_d;
    logic                  phase_q, phase_d;
    logic [7:0]            lo_q, lo_d;
    logic                  errh_q, errh_d;
    timing_t [N_TIMED-1:0] snap_q, tsel;
    timing_t               t_cur;
    logic split, mapped, start, active, half_done, last_half;
    logic [DW-1:0]         half_rd;
    logic [7:0]            byte_out;

    assign split     = req_word & req_addr[0];
    assign cur_addr  = req_addr + CPU_AW'(phase_q);
    assign mapped    = (region != RG_NONE);
    assign tsel      = (state_q == S_IDLE && !phase_q) ? cfg_live : snap_q;
    assign start     = (state_q == S_IDLE) && req_valid;
    assign active    = start || (state_q == S_WAIT);

    always_comb begin
        case (region)
            RG_FLASH: t_cur = tsel[0];
            RG_BOOT:  t_cur = tsel[1];
            RG_IO:    t_cur = tsel[2];
            default:  t_cur = '0;
        endcase
    end

    assign half_done = (start && t_cur.waits == '0) ||
                       (state_q == S_WAIT && cnt_q == '0);
    assign last_half = !split || phase_q;

    // slave side
    assign bus_stb   = active && mapped;
    assign bus_sel   = bus_stb ? sel_oh : '0;
    assign bus_we    = req_write;
    assign bus_word  = req_word && !split;
    assign bus_addr  = cur_addr[DEC_AW-1:0];
    assign byte_out  = phase_q ? req_wdata[15:8] : req_wdata[7:0];
    assign bus_wdata = bus_word ? req_wdata : {8'h00, byte_out};
    assign half_rd   = mapped ? bus_rdata : '0;

    // core side
    assign req_ready = half_done && last_half;
    assign req_err   = req_ready && (errh_q || !mapped);
    always_comb begin
        if (!req_ready)    req_rdata = '0;
        else if (split)    req_rdata = {half_rd[7:0], lo_q};
        else if (bus_word) req_rdata = half_rd;
        else               req_rdata = {8'h00, half_rd[7:0]};
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        phase_d = phase_q;
        lo_d    = lo_q;
        errh_d  = errh_q;
        case (state_q)
            S_IDLE: if (req_valid && t_cur.waits != '0) begin
                state_d = S_WAIT;
                cnt_d   = CNT_W'(t_cur.waits) - CNT_W'(1);
            end
            S_WAIT: if (cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
            S_HOLD: begin
                if (cnt_q == '0) state_d = S_IDLE;
                else             cnt_d   = cnt_q - CNT_W'(1);
            end
            default: state_d = S_IDLE;
        endcase
        if (half_done) begin
            if (split && !phase_q) begin
                phase_d = 1'b1;
                lo_d    = half_rd[7:0];
                errh_d  = !mapped;
            end else begin
                phase_d = 1'b0;
                errh_d  = 1'b0;
            end
            if (t_cur.hold != '0) begin
                state_d = S_HOLD;
                cnt_d   = CNT_W'(t_cur.hold) - CNT_W'(1);
            end else begin
                state_d = S_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            phase_q <= 1'b0;
            lo_q    <= '0;
            errh_q  <= 1'b0;
            snap_q  <= '1;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            phase_q <= phase_d;
            lo_q    <= lo_d;
            errh_q  <= errh_d;
            if (start && !phase_q) snap_q <= cfg_live;
        end
    end

    // R1: a strobed access addresses exactly one region
    p_sel_onehot_r1: assert property (@(posedge clk) disable iff (rst)
        bus_stb |-> $countones(bus_sel) == 1);
    // R2: SRAM finishes at once and leaves no gap behind it
    p_sram_single_r2: assert property (@(posedge clk) disable iff (rst)
        (start && region == RG_SRAM && !split) |-> req_ready ##1 (state_q == S_IDLE));
    // R3: slave-side fields stay steady across wait cycles
    p_wait_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_WAIT) |-> ($stable(bus_addr) && $stable(bus_we) && $stable(bus_sel)));
    // R4: a nonzero hold leaves the bus quiet in the next cycle
    p_hold_gap_r4: assert property (@(posedge clk) disable iff (rst)
        (half_done && t_cur.hold != '0) |=> (!bus_stb && !req_ready));
    // R7: captured timing cannot move while an access waits
    p_snap_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_WAIT && $past(state_q) == S_WAIT) |-> $stable(snap_q));
    // R10: an unmapped single access returns zero and selects nothing
    p_err_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (req_err && !split) |-> (req_rdata == '0 && bus_sel == '0));
endmodule

// File: rtl/wsb_ctrl.sv
module wsb_ctrl
    import wsb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [20:0]       req_addr,
    input  logic              req_word,
    input  logic              req_write,
    input  logic [15:0]       req_wdata,
    output logic              req_ready,
    output logic [15:0]       req_rdata,
    output logic              req_err,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_idx,
    input  logic [2:0]        cfg_wait,
    input  logic [1:0]        cfg_hold,
    output logic [3:0]        bus_sel,
    output logic              bus_stb,
    output logic              bus_we,
    output logic              bus_word,
    output logic [16:0]       bus_addr,
    output logic [15:0]       bus_wdata,
    input  logic [15:0]       bus_rdata
);
    timing_t [N_TIMED-1:0] cfg_table;
    logic [CPU_AW-1:0]     cur_addr;
    region_e               region;
    logic [N_SEL-1:0]      sel_oh;

    wsb_cfg u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .idx(cfg_idx),
        .waits(cfg_wait), .hold(cfg_hold), .table_q(cfg_table)
    );

    wsb_decode u_dec (
        .addr(cur_addr), .region(region), .sel_oh(sel_oh)
    );

    wsb_seq u_seq (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_addr(req_addr), .req_word(req_word),
        .req_write(req_write), .req_wdata(req_wdata),
        .req_ready(req_ready), .req_rdata(req_rdata), .req_err(req_err),
        .cfg_live(cfg_table), .cur_addr(cur_addr),
        .region(region), .sel_oh(sel_oh),
        .bus_sel(bus_sel), .bus_stb(bus_stb), .bus_we(bus_we),
        .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );
endmodule

// File: tb/sim_wsb_ctrl.sv
module sim_wsb_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 0, req_word = 0, req_write = 0;
    logic [20:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, req_err;
    logic [15:0] req_rdata;
    logic        cfg_we = 0;
    logic [1:0]  cfg_idx = '0;
    logic [2:0]  cfg_wait = '0;
    logic [1:0]  cfg_hold = '0;
    logic [3:0]  bus_sel;
    logic        bus_stb, bus_we, bus_word;
    logic [16:0] bus_addr;
    logic [15:0] bus_wdata, bus_rdata;

    int errors = 0, checks = 0, cyc = 0;

    always #2 clk = ~clk;

    wsb_ctrl u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_word(req_word), .req_write(req_write), .req_wdata(req_wdata),
        .req_ready(req_ready), .req_rdata(req_rdata), .req_err(req_err),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wait(cfg_wait), .cfg_hold(cfg_hold),
        .bus_sel(bus_sel), .bus_stb(bus_stb), .bus_we(bus_we), .bus_word(bus_word),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [7:0] mb(input logic [16:0] a);
        return a[7:0] ^ a[15:8] ^ {a[16], 7'h2A};
    endfunction

    // behavioural slaves: byte reads put junk in the upper lane
    assign bus_rdata = (bus_sel == 4'b0) ? 16'hDEAD :
                       bus_word ? {mb(bus_addr + 17'd1), mb(bus_addr)} :
                                  {8'hEE, mb(bus_addr)};

    // write log: one entry per distinct strobed half
    int          wr_cnt = 0;
    logic [16:0] wa [2];
    logic [15:0] wd [2];
    logic        ww [2];
    logic        prev_stb = 0;
    logic [16:0] prev_addr = '0;
    always @(negedge clk) begin
        if (bus_stb && bus_we && (!prev_stb || bus_addr != prev_addr)) begin
            if (wr_cnt < 2) begin
                wa[wr_cnt] = bus_addr;
                wd[wr_cnt] = bus_wdata;
                ww[wr_cnt] = bus_word;
            end
            wr_cnt = wr_cnt + 1;
        end
        prev_stb  = bus_stb;
        prev_addr = bus_addr;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected=<100000", cyc);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // called just after a rising edge; returns wait count before ready
    task automatic access(input logic [20:0] a, input logic w, input logic wr,
                          input logic [15:0] d, output int n,
                          output logic [15:0] rd, output logic e);
        req_valid = 1; req_addr = a; req_word = w; req_write = wr; req_wdata = d;
        n = 0;
        @(negedge clk);
        while (!req_ready && n < 100) begin
            n++;
            @(negedge clk);
        end
        rd = req_rdata;
        e  = req_err;
        @(posedge clk);
        #1 req_valid = 0;
    endtask

    task automatic setcfg(input logic [1:0] i, input logic [2:0] w, input logic [1:0] h);
        cfg_we = 1; cfg_idx = i; cfg_wait = w; cfg_hold = h;
        @(posedge clk);
        #1 cfg_we = 0;
    endtask

    task automatic idle(input int k);
        repeat (k) @(posedge clk);
        #1;
    endtask

    initial begin
        int n;
        logic [15:0] rd;
        logic e;
        logic [20:0] base [3];
        base[0] = 21'h00100; base[1] = 21'h10100; base[2] = 21'h1F000;

        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        check("R5 reset ready", {31'b0, req_ready}, 0);
        check("R5 reset stb", {31'b0, bus_stb}, 0);
        check("R5 reset err", {31'b0, req_err}, 0);
        @(posedge clk); #1;

        // R5: all entries slowest after reset
        for (int r = 0; r < 3; r++) begin
            idle(4);
            access(base[r], 1, 0, 0, n, rd, e);
            check("R5 reset wait", n, 7);
            check("R8 word data", rd, {mb(base[r][16:0] + 17'd1), mb(base[r][16:0])});
            access(21'h14000, 1, 0, 0, n, rd, e);
            check("R5 reset hold", n, 3);
        end

        // R3 R4 R6: sweep every wait/hold pair in every timed region
        for (int r = 0; r < 3; r++) begin
            for (int w = 0; w < 8; w++) begin
                for (int h = 0; h < 4; h++) begin
                    logic [20:0] a;
                    a = base[r] + 21'(w * 16 + h * 2);
                    setcfg(2'(r), 3'(w), 2'(h));
                    idle(4);
                    access(a, 1, 0, 0, n, rd, e);
                    check("R3 wait count", n, w);
                    check("R8 word read", rd, {mb(a[16:0] + 17'd1), mb(a[16:0])});
                    access(21'h14002, 1, 0, 0, n, rd, e);
                    check("R4 hold gap", n, h);
                end
            end
        end

        // R2: SRAM back to back
        idle(4);
        access(21'h14010, 1, 0, 0, n, rd, e);
        check("R2 sram single", n, 0);
        access(21'h14BFE, 0, 0, 0, n, rd, e);
        check("R2 sram next", n, 0);
        check("R8 byte read upper zero", rd, {8'h00, mb(17'h14BFE)});

        setcfg(0, 2, 1);
        setcfg(1, 1, 2);
        setcfg(2, 3, 0);
        idle(4);
        access(21'h00203, 0, 0, 0, n, rd, e);
        check("R8 flash byte read", rd, {8'h00, mb(17'h00203)});
        check("R3 flash byte wait", n, 2);

        // R9: split word inside flash and across flash/boot
        idle(4);
        access(21'h00301, 1, 0, 0, n, rd, e);
        check("R9 split flash latency", n, 6);
        check("R9 split flash data", rd, {mb(17'h00302), mb(17'h00301)});
        idle(4);
        access(21'h0FFFF, 1, 0, 0, n, rd, e);
        check("R9 split cross latency", n, 5);
        check("R9 split cross data", rd, {mb(17'h10000), mb(17'h0FFFF)});
        check("R9 split cross err", {31'b0, e}, 0);
        access(21'h14000, 0, 0, 0, n, rd, e);
        check("R9 boot hold after split", n, 2);

        // R11: write lanes
        idle(4);
        wr_cnt = 0;
        access(21'h00405, 0, 1, 16'hA55A, n, rd, e);
        check("R11 byte write count", wr_cnt, 1);
        check("R11 byte write addr", {15'b0, wa[0]}, 32'h00405);
        check("R11 byte write data", wd[0], 16'h005A);
        check("R11 byte write size", {31'b0, ww[0]}, 0);
        idle(4);
        wr_cnt = 0;
        access(21'h14011, 1, 1, 16'hBEEF, n, rd, e);
        check("R11 split write count", wr_cnt, 2);
        check("R11 split lo addr", {15'b0, wa[0]}, 32'h14011);
        check("R11 split lo data", wd[0], 16'h00EF);
        check("R11 split hi addr", {15'b0, wa[1]}, 32'h14012);
        check("R11 split hi data", wd[1], 16'h00BE);
        check("R9 sram split latency", n, 1);
        idle(4);
        wr_cnt = 0;
        access(21'h1F020, 1, 1, 16'h1234, n, rd, e);
        check("R11 word write data", wd[0], 16'h1234);
        check("R11 word write size", {31'b0, ww[0]}, 1);

        // R10: unmapped addresses
        idle(4);
        access(21'h1C000, 1, 0, 0, n, rd, e);
        check("R10 gap latency", n, 0);
        check("R10 gap err", {31'b0, e}, 1);
        check("R10 gap data", rd, 0);
        @(negedge clk);
        check("R10 err one cycle", {31'b0, req_err}, 0);
        @(posedge clk); #1;
        access(21'h30000, 0, 0, 0, n, rd, e);
        check("R10 high latency", n, 0);
        check("R10 high err", {31'b0, e}, 1);
        check("R10 high data", rd, 0);
        idle(2);
        access(21'h14BFF, 1, 0, 0, n, rd, e);
        check("R10 split tail latency", n, 1);
        check("R10 split tail err", {31'b0, e}, 1);
        check("R10 split tail data", rd, {8'h00, mb(17'h14BFF)});

        // R7: timing change during an access
        setcfg(0, 5, 0);
        idle(4);
        fork
            access(21'h00600, 1, 0, 0, n, rd, e);
            begin
                repeat (2) @(posedge clk);
                #1 cfg_we = 1; cfg_idx = 0; cfg_wait = 0; cfg_hold = 0;
                @(posedge clk);
                #1 cfg_we = 0;
            end
        join
        check("R7 in-flight keeps wait", n, 5);
        idle(2);
        access(21'h00600, 1, 0, 0, n, rd, e);
        check("R7 next uses new wait", n, 0);
        setcfg(0, 4, 0);
        idle(4);
        fork
            access(21'h00501, 1, 0, 0, n, rd, e);
            begin
                repeat (2) @(posedge clk);
                #1 cfg_we = 1; cfg_idx = 0; cfg_wait = 0; cfg_hold = 0;
                @(posedge clk);
                #1 cfg_we = 0;
            end
        join
        check("R7 split keeps snapshot", n, 9);
        check("R9 split data after change", rd, {mb(17'h00502), mb(17'h00501)});

        // R6: index 3 writes nothing
        setcfg(0, 6, 0);
        setcfg(1, 5, 0);
        setcfg(2, 4, 0);
        setcfg(3, 0, 0);
        for (int r = 0; r < 3; r++) begin
            idle(4);
            access(base[r], 1, 0, 0, n, rd, e);
            check("R6 index 3 ignored", n, 6 - r);
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule